// File: doc/BRIEF.md
# SPI serial memory command engine

This block is the serial front end of a byte-wide 128K x 8 memory. A bus master selects it with an active-low chip select, clocks an opcode and, for array access, a three-byte address into it on SI, then streams data in or out. The engine drives a byte-wide memory port (address, write data, write strobe, combinational read data). It exchanges single-cycle command strobes and permission flags with a separate protection unit, which owns the status byte. The array itself and the power-state timing live outside.

All serial pins are oversampled in the `clk` domain through a synchronizer of `SYNC_STAGES` flops. Each half period of SCK must last at least `SYNC_STAGES + 4` cycles of `clk`. The output pin is split into a data bit and an output enable, so the pad or the bench can model the tri-state.

Top module: `spi_mem_engine`

## Requirements
- R1: Opcode 06h pulses `wen_set_o`, 04h pulses `wen_clr_o`, B9h pulses `nap_o` and ABh pulses `resume_o`. Each pulse lasts one `clk` cycle, comes once when the opcode byte completes, and no other strobe fires with it.
- R2: SI is taken on the rising edge of SCK, and `so_o` changes only after a falling edge of SCK. Opcode, address and data travel most significant bit first.
- R3: Behaviour is identical whether SCK rests low (mode 0) or high (mode 3) when chip select falls. In mode 3 the falling edge that comes before the first rising edge has no effect.
- R4: A chip-select period carries one command only. After a single-byte command or a completed status write, further bytes produce no strobe and no write until chip select rises.
- R5: Read (03h) and write (02h) take three address bytes, most significant first. The start address is the low `ADDR_W` bits of that 24-bit value (default 17).
- R6: The address advances by one after each data byte and wraps from 2^`ADDR_W`-1 to 0. A single command may move any number of bytes.
- R7: A write data byte pulses `mem_we_o` with its address on `mem_addr_o` and its value on `mem_wdata_o`, but only when `wr_allow_i` is high for that address. Otherwise the byte is dropped, and the address still advances.
- R8: The bits of an incomplete final byte at chip-select rise are discarded and never written.
- R9: Status read (05h) shifts out `stat_rdata_i`, and repeats it for every further 8 clocks.
- R10: Status write (01h) pulses `stat_we_o` with the first data byte on `stat_wdata_o`, only when `stat_wr_allow_i` is high. Later bytes in the same selection are ignored.
- R11: `so_oe_o` is high only while read data or status is being shifted out in a selected period. It is low after reset, after deselect, and throughout all other commands.
- R12: An unknown opcode causes no strobe, no write and no output enable until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master |
| cs_n_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; low means high impedance |
| mem_addr_o | output | ADDR_W | Array byte address |
| mem_wdata_o | output | 8 | Array write data |
| mem_we_o | output | 1 | Array write strobe, one cycle |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o`, combinational |
| wr_allow_i | input | 1 | Protection unit: write to `mem_addr_o` permitted |
| stat_wr_allow_i | input | 1 | Protection unit: status write permitted |
| stat_rdata_i | input | 8 | Status byte from protection unit |
| stat_wdata_o | output | 8 | New status byte |
| stat_we_o | output | 1 | Status write strobe, one cycle |
| wen_set_o | output | 1 | Write-enable set strobe |
| wen_clr_o | output | 1 | Write-enable clear strobe |
| nap_o | output | 1 | Sleep request strobe |
| resume_o | output | 1 | Wake request strobe |

## Verification
A wrong phase, or a bit counter off by one, shows within one byte time. It appears as a misplaced strobe, a write at the wrong address, or output data shifted by one bit, and the read-back comparison catches it on the first data byte. A faulty address counter stays hidden until the first wrap. For that reason the write and read sweeps cover the whole reduced array and cross the top boundary, so any fault in the wrap shows as a run of mismatched bytes just past address zero. A stuck output enable appears as counted enable cycles during commands that send nothing.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    OP_WEN_SET = 8'h06,
    OP_WEN_CLR = 8'h04,
    OP_STAT_RD = 8'h05,
    OP_STAT_WR = 8'h01,
    OP_ARR_RD  = 8'h03,
    OP_ARR_WR  = 8'h02,
    OP_NAP     = 8'hB9,
    OP_RESUME  = 8'hAB
  } opcode_e;

  typedef enum logic [2:0] {
    PH_OPC,   // collecting opcode
    PH_ARD,   // collecting address for a read
    PH_AWR,   // collecting address for a write
    PH_WDATA, // array write data
    PH_RDATA, // array read data
    PH_SRD,   // status out
    PH_SWR,   // status in
    PH_IGN    // ignore until deselect
  } phase_e;

  function automatic phase_e opc_next(input logic [BYTE_W-1:0] b);
    case (b)
      OP_ARR_RD:  return PH_ARD;
      OP_ARR_WR:  return PH_AWR;
      OP_STAT_RD: return PH_SRD;
      OP_STAT_WR: return PH_SWR;
      default:    return PH_IGN;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sel_o,
  output logic si_o
);
  logic [STAGES-1:0] sck_q, csn_q, si_q;
  logic              sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      csn_q    <= '1;
      si_q     <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], sck_i};
      csn_q    <= {csn_q[STAGES-2:0], cs_n_i};
      si_q     <= {si_q[STAGES-2:0], si_i};
      sck_last <= sck_q[STAGES-1];
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_last;
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_last;
  assign sel_o      = ~csn_q[STAGES-1];
  assign si_o       = si_q[STAGES-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte #(
  parameter int W = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bit_en,
  input  logic          bit_i,
  output logic [W-1:0]  byte_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else if (clear) begin
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= bit_en && (cnt_o == CW'(W-1));
      if (bit_en) begin
        byte_o <= {byte_o[W-2:0], bit_i};
        cnt_o  <= (cnt_o == CW'(W-1)) ? '0 : cnt_o + CW'(1);
      end
    end
  end

  // a deselect wipes any partial byte before it can complete
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_o == '0 && !done_o));
endmodule

// File: rtl/spi_tx_byte.sv
module spi_tx_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clear) sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end

  assign bit_o = sh[W-1];
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ABW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int CW  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              wr_allow_i,
  input  logic              stat_wr_allow_i,
  input  logic [BYTE_W-1:0] stat_rdata_i,
  output logic [BYTE_W-1:0] stat_wdata_o,
  output logic              stat_we_o,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              nap_o,
  output logic              resume_o
);
  // ---- arithmetic kept in functions ----
  function automatic logic [ADDR_W-1:0] addr_shift(input logic [ADDR_W-1:0] a,
                                                   input logic [BYTE_W-1:0] b);
    logic [ADDR_W+BYTE_W-1:0] w;
    w = {a, b};
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return (a == {ADDR_W{1'b1}}) ? '0 : a + ADDR_W'(1);
  endfunction

  // ---- pin conditioning ----
  logic sck_rise, sck_fall, sel, si_s;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .si_i(si_i),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sel_o(sel), .si_o(si_s)
  );

  // ---- receive ----
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_done;
  logic [CW-1:0]     bit_cnt;

  spi_rx_byte #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(!sel), .bit_en(sel && sck_rise),
    .bit_i(si_s), .byte_o(rx_byte), .done_o(rx_done), .cnt_o(bit_cnt)
  );

  // ---- phase state ----
  phase_e            ph_q;
  logic [ABW-1:0]    abyte_q;
  logic [ADDR_W-1:0] addr_q;
  logic              oe_q;

  // named internal events
  logic opc_done, addr_done, wbyte_done, swr_done, out_phase, tx_load, tx_shift;
  assign opc_done   = sel && rx_done && (ph_q == PH_OPC);
  assign addr_done  = sel && rx_done && (ph_q == PH_ARD || ph_q == PH_AWR);
  assign wbyte_done = sel && rx_done && (ph_q == PH_WDATA);
  assign swr_done   = sel && rx_done && (ph_q == PH_SWR);
  assign out_phase  = (ph_q == PH_RDATA) || (ph_q == PH_SRD);
  assign tx_load    = sel && sck_fall && out_phase && (bit_cnt == '0);
  assign tx_shift   = sel && sck_fall && out_phase && (bit_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_OPC;
      abyte_q <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
    end else if (!sel) begin
      ph_q    <= PH_OPC;
      abyte_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (opc_done) ph_q <= opc_next(rx_byte);
      if (addr_done) begin
        addr_q  <= addr_shift(addr_q, rx_byte);
        abyte_q <= abyte_q + ABW'(1);
        if (abyte_q == ABW'(ADDR_BYTES-1))
          ph_q <= (ph_q == PH_ARD) ? PH_RDATA : PH_WDATA;
      end
      if (wbyte_done) addr_q <= addr_step(addr_q);
      if (swr_done)   ph_q   <= PH_IGN;
      if (tx_load) begin
        oe_q <= 1'b1;
        if (ph_q == PH_RDATA) addr_q <= addr_step(addr_q);
      end
    end
  end

  // ---- transmit ----
  spi_tx_byte #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(!sel), .load(tx_load), .shift(tx_shift),
    .din((ph_q == PH_RDATA) ? mem_rdata_i : stat_rdata_i), .bit_o(so_o)
  );

  // ---- outputs ----
  assign so_oe_o      = oe_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = rx_byte;
  assign mem_we_o     = wbyte_done && wr_allow_i;
  assign stat_wdata_o = rx_byte;
  assign stat_we_o    = swr_done && stat_wr_allow_i;
  assign wen_set_o    = opc_done && (rx_byte == OP_WEN_SET);
  assign wen_clr_o    = opc_done && (rx_byte == OP_WEN_CLR);
  assign nap_o        = opc_done && (rx_byte == OP_NAP);
  assign resume_o     = opc_done && (rx_byte == OP_RESUME);

  // ---- assertions ----
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set_o, wen_clr_o, nap_o, resume_o, stat_we_o, mem_we_o}));

  p_so_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sck_fall) |=> $stable(so_o));

  p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set_o || wen_clr_o || nap_o || resume_o || stat_we_o) |=> (ph_q == PH_IGN));

  p_addr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_done |=> (mem_addr_o == addr_step($past(mem_addr_o))));

  p_oe_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o |-> out_phase);

  p_oe_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe_o);

  p_ign_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IGN && sel) |=> (ph_q == PH_IGN));
endmodule

// File: tb/tb_spi_mem_engine.sv
module tb_spi_mem_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;       // clk cycles per SCK half period
  localparam int AW         = 9;
  localparam int DEPTH      = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, sck, cs_n, si;
  logic          so, so_oe, mem_we, stat_we, wen_set, wen_clr, nap, resume;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata, stat_wdata, sreg;
  logic [AW:0]   wlim;
  logic          sw_allow, wr_allow, fill_req;

  logic [7:0] mem     [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  function automatic logic [7:0] fill_pat(input int k);
    return 8'((k * 13 + 5) & 255);
  endfunction

  assign mem_rdata = mem[mem_addr];
  assign wr_allow  = ({1'b0, mem_addr} < wlim);

  spi_mem_engine #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .wr_allow_i(wr_allow),
    .stat_wr_allow_i(sw_allow), .stat_rdata_i(sreg), .stat_wdata_o(stat_wdata),
    .stat_we_o(stat_we), .wen_set_o(wen_set), .wen_clr_o(wen_clr),
    .nap_o(nap), .resume_o(resume)
  );

  // array model and event counters
  int n_set = 0, n_clr = 0, n_nap = 0, n_res = 0, n_swe = 0, oe_cyc = 0;
  logic [7:0] last_sw = 8'h00;
  always @(posedge clk) begin
    if (fill_req) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= fill_pat(k);
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    if (wen_set) n_set++;
    if (wen_clr) n_clr++;
    if (nap)     n_nap++;
    if (resume)  n_res++;
    if (stat_we) begin n_swe++; last_sw <= stat_wdata; end
    if (so_oe)   oe_cyc++;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i];
      wait_clk(HALF);
      rx[i] = so;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic begin_tx(input bit m3);
    @(negedge clk);
    sck = m3;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_tx(input bit m3);
    if (!m3) begin sck = 1'b0; wait_clk(HALF); end
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  int mism;
  task automatic cmp_mem(input string req);
    mism = 0;
    for (int k = 0; k < DEPTH; k++) if (mem[k] !== exp_mem[k]) mism++;
    check(mism == 0, req, mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired before all requirement checks");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx, d;
    logic [7:0] ops [4];
    int s_set, s_clr, s_nap, s_res, s_swe, s_oe, tot0, base;
    ops[0] = 8'h06; ops[1] = 8'h04; ops[2] = 8'hB9; ops[3] = 8'hAB;

    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    wlim = (AW+1)'(DEPTH); sw_allow = 1'b1; sreg = 8'h00; fill_req = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // reset state (R11)
    check(so_oe == 1'b0, "R11 reset oe", so_oe, 0);
    check(mem_we == 1'b0 && stat_we == 1'b0, "R1 reset strobes", {mem_we, stat_we}, 0);

    fill_req = 1'b1; @(negedge clk); fill_req = 1'b0; @(negedge clk);
    for (int k = 0; k < DEPTH; k++) exp_mem[k] = fill_pat(k);

    // R1 / R3: single-byte commands in both modes
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 4; j++) begin
        s_set = n_set; s_clr = n_clr; s_nap = n_nap; s_res = n_res;
        tot0 = n_set + n_clr + n_nap + n_res + n_swe;
        begin_tx(m[0]); xbyte(ops[j], rx); end_tx(m[0]);
        case (j)
          0: check(n_set == s_set + 1, "R1 R3 set strobe", n_set - s_set, 1);
          1: check(n_clr == s_clr + 1, "R1 R3 clr strobe", n_clr - s_clr, 1);
          2: check(n_nap == s_nap + 1, "R1 R3 nap strobe", n_nap - s_nap, 1);
          default: check(n_res == s_res + 1, "R1 R3 resume strobe", n_res - s_res, 1);
        endcase
        check(n_set + n_clr + n_nap + n_res + n_swe == tot0 + 1, "R1 single strobe",
              n_set + n_clr + n_nap + n_res + n_swe - tot0, 1);
      end
    end

    // R4: bytes after a one-byte command are ignored
    s_set = n_set; s_clr = n_clr; s_nap = n_nap;
    begin_tx(1'b0); xbyte(8'h06, rx); xbyte(8'h04, rx); xbyte(8'hB9, rx); end_tx(1'b0);
    check(n_set == s_set + 1 && n_clr == s_clr && n_nap == s_nap, "R4 one command",
          (n_set - s_set) * 16 + (n_clr - s_clr) + (n_nap - s_nap), 16);

    // R12: unknown opcode
    tot0 = n_set + n_clr + n_nap + n_res + n_swe; s_oe = oe_cyc;
    begin_tx(1'b1); xbyte(8'h5A, rx); xbyte(8'h06, rx); xbyte(8'h02, rx);
    xbyte(8'h00, rx); xbyte(8'h33, rx); end_tx(1'b1);
    check(n_set + n_clr + n_nap + n_res + n_swe == tot0, "R12 no strobe",
          n_set + n_clr + n_nap + n_res + n_swe - tot0, 0);
    check(oe_cyc == s_oe, "R12 no oe", oe_cyc - s_oe, 0);
    cmp_mem("R12 memory untouched");

    // R2 R5 R6: long write crossing the top, upper address bits ignored
    s_oe = oe_cyc;
    base = 32'h00A73DF0 % DEPTH;
    begin_tx(1'b0); xbyte(8'h02, rx); send_addr(24'hA73DF0);
    for (int i = 0; i < DEPTH + 8; i++) begin
      d = 8'((i * 7 + 3) & 255);
      xbyte(d, rx);
      exp_mem[(base + i) % DEPTH] = d;
    end
    end_tx(1'b0);
    check(oe_cyc == s_oe, "R11 oe low during write", oe_cyc - s_oe, 0);
    for (int k = 0; k < DEPTH; k++)
      check(mem[k] === exp_mem[k], "R2 R5 R6 write sweep", mem[k], exp_mem[k]);

    // R2 R3 R5 R6: long read in mode 3 crossing the top
    s_oe = oe_cyc;
    base = 32'h005E4207 % DEPTH;
    begin_tx(1'b1); xbyte(8'h03, rx); send_addr(24'h5E4207);
    for (int i = 0; i < DEPTH + 3; i++) begin
      xbyte(8'hFF, rx);
      check(rx === exp_mem[(base + i) % DEPTH], "R2 R3 R6 read sweep", rx,
            exp_mem[(base + i) % DEPTH]);
    end
    end_tx(1'b1);
    check(oe_cyc > s_oe, "R11 oe during read", oe_cyc - s_oe, 1);
    check(so_oe == 1'b0, "R11 oe after deselect", so_oe, 0);

    // R7: protection boundary at 0x80
    wlim = (AW+1)'(9'h080);
    begin_tx(1'b0); xbyte(8'h02, rx); send_addr(24'h00007C);
    for (int i = 0; i < 8; i++) begin
      d = 8'hC0 + 8'(i);
      xbyte(d, rx);
      if (32'h7C + i < 32'h80) exp_mem[32'h7C + i] = d;
    end
    end_tx(1'b0);
    wlim = (AW+1)'(DEPTH);
    for (int k = 32'h7A; k < 32'h86; k++)
      check(mem[k] === exp_mem[k], "R7 protected write", mem[k], exp_mem[k]);

    // R8: partial trailing byte dropped
    begin_tx(1'b0); xbyte(8'h02, rx); send_addr(24'h000040);
    xbyte(8'h11, rx); xbits(8'h22, 5, rx); end_tx(1'b0);
    exp_mem[32'h40] = 8'h11;
    check(mem[32'h40] === 8'h11, "R8 full byte kept", mem[32'h40], 8'h11);
    check(mem[32'h41] === exp_mem[32'h41], "R8 partial dropped", mem[32'h41], exp_mem[32'h41]);

    // R9: status read repeats, both modes
    sreg = 8'hA5;
    begin_tx(1'b0); xbyte(8'h05, rx);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, rx);
      check(rx === 8'hA5, "R9 status mode0", rx, 8'hA5);
    end
    end_tx(1'b0);
    sreg = 8'h3C;
    begin_tx(1'b1); xbyte(8'h05, rx);
    for (int i = 0; i < 2; i++) begin
      xbyte(8'h00, rx);
      check(rx === 8'h3C, "R9 R3 status mode3", rx, 8'h3C);
    end
    end_tx(1'b1);

    // R10: status write, allowed then refused
    s_swe = n_swe; s_oe = oe_cyc;
    begin_tx(1'b0); xbyte(8'h01, rx); xbyte(8'h9C, rx); xbyte(8'h55, rx); end_tx(1'b0);
    check(n_swe == s_swe + 1, "R10 one status write", n_swe - s_swe, 1);
    check(last_sw === 8'h9C, "R10 status value", last_sw, 8'h9C);
    sw_allow = 1'b0;
    begin_tx(1'b1); xbyte(8'h01, rx); xbyte(8'h12, rx); end_tx(1'b1);
    sw_allow = 1'b1;
    check(n_swe == s_swe + 1, "R10 refused write", n_swe - s_swe, 1);
    check(last_sw === 8'h9C, "R10 value kept", last_sw, 8'h9C);
    check(oe_cyc == s_oe, "R11 oe low during status write", oe_cyc - s_oe, 0);
    cmp_mem("R4 R10 memory untouched");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule